// File: doc/BRIEF.md
# Mode-Tracking Control Register File

This block holds the control state of a processor core: the control registers, the extended feature register, the flags image, the code-segment attributes, and the real and effective bases of eight segments. It also holds a time-stamp offset and a derived operating-mode register. One write port takes an index, data and an enable. One read port returns the indexed value combinationally. Some writes have side effects. They move the core between legacy and long operation, pick the submode, copy the code-segment privilege level, keep the effective segment bases in step with the real bases, and pulse TLB invalidations.

The operating mode is a two-state machine. The states are OPM_LEGACY, which is the reset state, and OPM_LONG. Transition T_ENTER_LONG runs from OPM_LEGACY to OPM_LONG when a CR0 write turns paging on while the long-mode-enable bit is set. Transition T_LEAVE_LONG runs back when a CR0 write turns paging off with the same bit set. Inside each state a submode is kept:
- In OPM_LONG the submode is SUB_64 or SUB_COMPAT.
- In OPM_LEGACY the submode is SUB_REAL, SUB_PROT or SUB_V86.

The invalidate outputs are each wired to both the instruction TLB and the data TLB.

Index map (6-bit index):

| Index | Register |
|---|---|
| 0, 2, 3, 4, 8 | CR0, CR2, CR3, CR4, CR8 |
| 16 | Extended feature register (EFER) |
| 17 | Flags image |
| 18 | Code-segment attributes |
| 19 | Mode register |
| 20 | Time stamp |
| 24–31 | Real segment bases, slots ES, CS, SS, DS, FS, GS, TR, IDTR |
| 32–39 | Effective bases, same slot order |

Every other index is illegal.

Top module: `crf_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears every register to zero, except CR0 bit 4 (ET), which resets to 1. After reset the mode is OPM_LEGACY (`cur_mode`=0), the submode is SUB_REAL (`cur_submode`=0), the privilege level is 0, and `inv_all`, `inv_nonglobal` and `wr_err` are low.
- R2: The illegal indices are 1, 5–7, 9–15 (unused control registers) and every index not in the map. Reading one drives `rd_err` high and `rd_data` to zero in the same cycle. Writing one changes no register and raises `wr_err` for the following cycle.
- R3: CR0 bit 4 reads as 1 whatever value was written.
- R4: A write to index 20 stores the written value minus the free-running cycle count. A read returns the stored value plus the cycle count, modulo 2^DW. So a read k cycles after the write's clock edge returns the written value plus k.
- R5: When a CR0 write toggles bit 31 (PG) while EFER bit 0 (LME) is set, turning PG on sets EFER bit 1 (LMA) and enters OPM_LONG. Turning PG off clears LMA and enters OPM_LEGACY. With LME clear, neither LMA nor the mode changes.
- R6: Every CR0 write re-derives the submode. In OPM_LONG it is SUB_64 (4) when code-segment attribute bit 2 (LM) is set, and SUB_COMPAT (3) otherwise. In OPM_LEGACY it is SUB_V86 (2) when flags bit 17 (VM) is set, SUB_PROT (1) when the written CR0 bit 0 (PE) is set, and SUB_REAL (0) otherwise.
- R7: A CR0 write that toggles PG raises `inv_all` for exactly the cycle after the write.
- R8: Every CR3 write raises `inv_nonglobal` for the cycle after the write.
- R9: A CR4 write that toggles bit 4, bit 5 or bit 7 raises `inv_all` for the cycle after the write. Toggling other CR4 bits raises nothing.
- R10: A code-segment attribute write that changes LM to 1 zeroes the effective bases of slots ES, CS, SS and DS, and in OPM_LONG selects SUB_64. A change of LM to 0 reloads those four from their real bases, and in OPM_LONG selects SUB_COMPAT.
- R11: Every code-segment attribute write copies bits 1:0 (DPL) into the current privilege level. The mode register at index 19 reads {cpl[5:4], submode[3:1], mode[0]}.
- R12: A write to the FS, GS, TR or IDTR real base also writes its effective base. A write to the ES, CS, SS or DS real base also writes its effective base only when LMA or the code-segment LM bit is clear.
- R13: A read of an index written in the same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 6 | Write index |
| wr_data | input | DW | Write data |
| rd_idx | input | 6 | Read index |
| rd_data | output | DW | Combinational read data |
| rd_err | output | 1 | Read index is illegal |
| wr_err | output | 1 | Previous-cycle write used an illegal index |
| inv_all | output | 1 | Full invalidate pulse to both TLBs |
| inv_nonglobal | output | 1 | Non-global invalidate pulse to both TLBs |
| cur_mode | output | 1 | 0 legacy, 1 long |
| cur_submode | output | 3 | Submode encoding of R6 |
| cur_cpl | output | 2 | Current privilege level |

## Verification
The bench builds the block with DW=32. DW cannot be smaller, because paging sits in CR0 bit 31. At this width the time-stamp sum wraps past 2^32 within two cycles of writing a value near the top of the range, which exercises the modular offset arithmetic. The mode walk then covers:
- entry into long mode and exit from it;
- a paging toggle with long-mode-enable clear;
- both directions of the code-segment LM change;
- every submode.

// File: rtl/crf_pkg.sv
package crf_pkg;
    localparam int IDX_W = 6;
    localparam int NSEG  = 8;

    localparam logic [IDX_W-1:0] IDX_CR0    = 6'd0;
    localparam logic [IDX_W-1:0] IDX_CR2    = 6'd2;
    localparam logic [IDX_W-1:0] IDX_CR3    = 6'd3;
    localparam logic [IDX_W-1:0] IDX_CR4    = 6'd4;
    localparam logic [IDX_W-1:0] IDX_CR8    = 6'd8;
    localparam logic [IDX_W-1:0] IDX_EFER   = 6'd16;
    localparam logic [IDX_W-1:0] IDX_FLAGS  = 6'd17;
    localparam logic [IDX_W-1:0] IDX_CSATTR = 6'd18;
    localparam logic [IDX_W-1:0] IDX_MODE   = 6'd19;
    localparam logic [IDX_W-1:0] IDX_TSC    = 6'd20;
    localparam logic [2:0]       GRP_BASE   = 3'b011;  // 24..31
    localparam logic [2:0]       GRP_EFF    = 3'b100;  // 32..39
    localparam int               SLOT_FS    = 4;       // slots below this are ES,CS,SS,DS

    localparam int CR0_PE   = 0;
    localparam int CR0_ET   = 4;
    localparam int CR0_PG   = 31;
    localparam int CR4_PSE  = 4;
    localparam int CR4_PAE  = 5;
    localparam int CR4_PGE  = 7;
    localparam int EFER_LME = 0;
    localparam int EFER_LMA = 1;
    localparam int FLG_VM   = 17;
    localparam int CSA_LM   = 2;

    typedef enum logic {
        OPM_LEGACY = 1'b0,
        OPM_LONG   = 1'b1
    } opmode_e;

    typedef enum logic [2:0] {
        SUB_REAL   = 3'd0,
        SUB_PROT   = 3'd1,
        SUB_V86    = 3'd2,
        SUB_COMPAT = 3'd3,
        SUB_64     = 3'd4
    } submode_e;

    function automatic logic idx_legal(input logic [IDX_W-1:0] i);
        case (i)
            IDX_CR0, IDX_CR2, IDX_CR3, IDX_CR4, IDX_CR8,
            IDX_EFER, IDX_FLAGS, IDX_CSATTR, IDX_MODE, IDX_TSC: return 1'b1;
            default: return (i[5:3] == GRP_BASE) || (i[5:3] == GRP_EFF);
        endcase
    endfunction
endpackage

// File: rtl/crf_idx_decode.sv
module crf_idx_decode import crf_pkg::*; (
    input  logic [IDX_W-1:0] idx,
    output logic             legal
);
    assign legal = idx_legal(idx);
endmodule

// File: rtl/crf_cycle_ctr.sv
module crf_cycle_ctr #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst,
    output logic [DW-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
    end
endmodule

// File: rtl/crf_mode_next.sv
module crf_mode_next import crf_pkg::*; (
    input  logic     wr_cr0,
    input  logic     wr_csattr,
    input  logic     wd_pg,
    input  logic     wd_pe,
    input  logic     wd_lm,
    input  logic     cr0_pg,
    input  logic     efer_lme,
    input  logic     efer_lma,
    input  logic     flags_vm,
    input  logic     csattr_lm,
    input  opmode_e  mode_q,
    input  submode_e sub_q,
    output opmode_e  mode_d,
    output submode_e sub_d,
    output logic     lma_d,
    output logic     pg_tog,
    output logic     lm_tog
);
    assign pg_tog = wd_pg ^ cr0_pg;
    assign lm_tog = wd_lm ^ csattr_lm;

    always_comb begin
        mode_d = mode_q;
        sub_d  = sub_q;
        lma_d  = efer_lma;
        if (wr_cr0) begin
            if (pg_tog && efer_lme) begin
                mode_d = wd_pg ? OPM_LONG : OPM_LEGACY;
                lma_d  = wd_pg;
            end
            unique case (mode_d)
                OPM_LONG:   sub_d = csattr_lm ? SUB_64 : SUB_COMPAT;
                OPM_LEGACY: sub_d = flags_vm ? SUB_V86 : (wd_pe ? SUB_PROT : SUB_REAL);
            endcase
        end else if (wr_csattr && lm_tog && mode_q == OPM_LONG) begin
            sub_d = wd_lm ? SUB_64 : SUB_COMPAT;
        end
    end
endmodule

// File: rtl/crf_regfile.sv
module crf_regfile import crf_pkg::*; #(
    parameter int DW = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DW-1:0]    rd_data,
    output logic             rd_err,
    output logic             wr_err,
    output logic             inv_all,
    output logic             inv_nonglobal,
    output logic             cur_mode,
    output logic [2:0]       cur_submode,
    output logic [1:0]       cur_cpl
);
    localparam int NPORT = 2;

    logic [DW-1:0] cr0_q, cr2_q, cr3_q, cr4_q, cr8_q;
    logic [DW-1:0] efer_q, flags_q, csattr_q, tsc_off_q;
    logic [DW-1:0] base_q [NSEG];
    logic [DW-1:0] eff_q  [NSEG];
    opmode_e       mode_q, mode_d;
    submode_e      sub_q, sub_d;
    logic [1:0]    cpl_q;
    logic          wr_err_q, inv_all_q, inv_ng_q;
    logic          lma_d, pg_tog, lm_tog;
    logic [DW-1:0] cyc;
    logic          wr_ok;

    logic [IDX_W-1:0] dec_idx   [NPORT];
    logic             dec_legal [NPORT];
    assign dec_idx[0] = rd_idx;
    assign dec_idx[1] = wr_idx;

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        crf_idx_decode u_dec (.idx(dec_idx[p]), .legal(dec_legal[p]));
    end

    assign wr_ok = wr_en && dec_legal[1];

    crf_cycle_ctr #(.DW(DW)) u_cyc (.clk(clk), .rst(rst), .count(cyc));

    crf_mode_next u_mode (
        .wr_cr0   (wr_ok && wr_idx == IDX_CR0),
        .wr_csattr(wr_ok && wr_idx == IDX_CSATTR),
        .wd_pg    (wr_data[CR0_PG]),
        .wd_pe    (wr_data[CR0_PE]),
        .wd_lm    (wr_data[CSA_LM]),
        .cr0_pg   (cr0_q[CR0_PG]),
        .efer_lme (efer_q[EFER_LME]),
        .efer_lma (efer_q[EFER_LMA]),
        .flags_vm (flags_q[FLG_VM]),
        .csattr_lm(csattr_q[CSA_LM]),
        .mode_q   (mode_q),
        .sub_q    (sub_q),
        .mode_d   (mode_d),
        .sub_d    (sub_d),
        .lma_d    (lma_d),
        .pg_tog   (pg_tog),
        .lm_tog   (lm_tog)
    );

    // State register and write side effects
    always_ff @(posedge clk) begin
        if (rst) begin
            cr0_q         <= '0;
            cr0_q[CR0_ET] <= 1'b1;
            cr2_q <= '0; cr3_q <= '0; cr4_q <= '0; cr8_q <= '0;
            efer_q <= '0; flags_q <= '0; csattr_q <= '0; tsc_off_q <= '0;
            for (int s = 0; s < NSEG; s++) begin
                base_q[s] <= '0;
                eff_q[s]  <= '0;
            end
            mode_q    <= OPM_LEGACY;
            sub_q     <= SUB_REAL;
            cpl_q     <= '0;
            wr_err_q  <= 1'b0;
            inv_all_q <= 1'b0;
            inv_ng_q  <= 1'b0;
        end else begin
            wr_err_q  <= wr_en && !dec_legal[1];
            inv_all_q <= 1'b0;
            inv_ng_q  <= 1'b0;
            if (wr_ok) begin
                case (wr_idx)
                    IDX_CR0: begin
                        cr0_q            <= wr_data;
                        cr0_q[CR0_ET]    <= 1'b1;
                        efer_q[EFER_LMA] <= lma_d;
                        mode_q           <= mode_d;
                        sub_q            <= sub_d;
                        inv_all_q        <= pg_tog;
                    end
                    IDX_CR2: cr2_q <= wr_data;
                    IDX_CR3: begin
                        cr3_q    <= wr_data;
                        inv_ng_q <= 1'b1;
                    end
                    IDX_CR4: begin
                        cr4_q     <= wr_data;
                        inv_all_q <= (cr4_q[CR4_PSE] ^ wr_data[CR4_PSE])
                                   | (cr4_q[CR4_PAE] ^ wr_data[CR4_PAE])
                                   | (cr4_q[CR4_PGE] ^ wr_data[CR4_PGE]);
                    end
                    IDX_CR8:   cr8_q   <= wr_data;
                    IDX_EFER:  efer_q  <= wr_data;
                    IDX_FLAGS: flags_q <= wr_data;
                    IDX_CSATTR: begin
                        csattr_q <= wr_data;
                        sub_q    <= sub_d;
                        cpl_q    <= wr_data[1:0];
                        if (lm_tog) begin
                            for (int s = 0; s < SLOT_FS; s++)
                                eff_q[s] <= wr_data[CSA_LM] ? '0 : base_q[s];
                        end
                    end
                    IDX_MODE: begin
                        mode_q <= opmode_e'(wr_data[0]);
                        sub_q  <= submode_e'(wr_data[3:1]);
                        cpl_q  <= wr_data[5:4];
                    end
                    IDX_TSC: tsc_off_q <= wr_data - cyc;
                    default: begin
                        if (wr_idx[5:3] == GRP_BASE) begin
                            base_q[wr_idx[2:0]] <= wr_data;
                            if (int'(wr_idx[2:0]) >= SLOT_FS ||
                                !(efer_q[EFER_LMA] && csattr_q[CSA_LM]))
                                eff_q[wr_idx[2:0]] <= wr_data;
                        end else begin
                            eff_q[wr_idx[2:0]] <= wr_data;
                        end
                    end
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        rd_data = '0;
        if (dec_legal[0]) begin
            case (rd_idx)
                IDX_CR0:    rd_data = cr0_q;
                IDX_CR2:    rd_data = cr2_q;
                IDX_CR3:    rd_data = cr3_q;
                IDX_CR4:    rd_data = cr4_q;
                IDX_CR8:    rd_data = cr8_q;
                IDX_EFER:   rd_data = efer_q;
                IDX_FLAGS:  rd_data = flags_q;
                IDX_CSATTR: rd_data = csattr_q;
                IDX_MODE:   rd_data[5:0] = {cpl_q, sub_q, mode_q};
                IDX_TSC:    rd_data = tsc_off_q + cyc;
                default:    rd_data = (rd_idx[5:3] == GRP_BASE) ? base_q[rd_idx[2:0]]
                                                                : eff_q[rd_idx[2:0]];
            endcase
        end
    end

    assign rd_err        = !dec_legal[0];
    assign wr_err        = wr_err_q;
    assign inv_all       = inv_all_q;
    assign inv_nonglobal = inv_ng_q;
    assign cur_mode      = mode_q;
    assign cur_submode   = sub_q;
    assign cur_cpl       = cpl_q;
endmodule

// File: rtl/crf_checker.sv
module crf_checker import crf_pkg::*; #(
    parameter int DW = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [DW-1:0]    wr_data,
    input logic [IDX_W-1:0] rd_idx,
    input logic [DW-1:0]    rd_data,
    input logic             rd_err,
    input logic             wr_err,
    input logic             inv_all,
    input logic             inv_nonglobal,
    input logic             cur_mode,
    input logic [2:0]       cur_submode,
    input logic [1:0]       cur_cpl
);
    logic started;
    always_ff @(posedge clk) begin
        if (rst) started <= 1'b0;
        else     started <= 1'b1;
    end

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!inv_all && !inv_nonglobal && !wr_err && !cur_mode &&
                 cur_submode == 3'd0 && cur_cpl == 2'd0));

    a_r2_write_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !idx_legal(wr_idx)) |=> wr_err);

    a_r2_read_zero: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> rd_data == '0);

    a_r3_et_set: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == IDX_CR0) |-> rd_data[CR0_ET]);

    a_r4_tsc_step: assert property (@(posedge clk) disable iff (rst)
        (started && rd_idx == IDX_TSC && $past(rd_idx == IDX_TSC) &&
         !$past(wr_en && wr_idx == IDX_TSC))
        |-> rd_data == $past(rd_data) + 1'b1);

    a_r7_flush_source: assert property (@(posedge clk) disable iff (rst)
        inv_all |-> (started && $past(wr_en && (wr_idx == IDX_CR0 || wr_idx == IDX_CR4))));

    a_r8_cr3_flush: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_CR3) |=> inv_nonglobal);

    a_r11_cpl_copy: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == IDX_CSATTR) |=> cur_cpl == $past(wr_data[1:0]));
endmodule

bind crf_regfile crf_checker #(.DW(DW)) u_crf_checker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_err(rd_err), .wr_err(wr_err),
    .inv_all(inv_all), .inv_nonglobal(inv_nonglobal), .cur_mode(cur_mode),
    .cur_submode(cur_submode), .cur_cpl(cur_cpl)
);

// File: tb/test_crf_regfile.sv
module test_crf_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk, rst, wr_en;
    logic [5:0]    wr_idx, rd_idx;
    logic [DW-1:0] wr_data, rd_data;
    logic          rd_err, wr_err, inv_all, inv_nonglobal, cur_mode;
    logic [2:0]    cur_submode;
    logic [1:0]    cur_cpl;
    int checks = 0;
    int fails  = 0;

    crf_regfile #(.DW(DW)) i_crf_regfile (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_err(rd_err), .wr_err(wr_err),
        .inv_all(inv_all), .inv_nonglobal(inv_nonglobal), .cur_mode(cur_mode),
        .cur_submode(cur_submode), .cur_cpl(cur_cpl)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic          we;
        logic [5:0]    widx;
        logic [31:0]   wdata;
        logic [5:0]    ridx;
        logic [31:0]   exp;
    } vec_t;

    localparam vec_t VEC_TBL [12] = '{
        '{1'b1, 6'd2,  32'h0000_1234, 6'd2,  32'h0},          // R13 old value
        '{1'b0, 6'd0,  32'h0,         6'd2,  32'h0000_1234},
        '{1'b1, 6'd0,  32'h0000_0001, 6'd0,  32'h0000_0010},  // R13
        '{1'b0, 6'd0,  32'h0,         6'd0,  32'h0000_0011},  // R3
        '{1'b1, 6'd8,  32'h0000_000F, 6'd8,  32'h0},
        '{1'b0, 6'd0,  32'h0,         6'd8,  32'h0000_000F},
        '{1'b1, 6'd28, 32'h0000_AAAA, 6'd36, 32'h0},          // FS base
        '{1'b0, 6'd0,  32'h0,         6'd36, 32'h0000_AAAA},  // R12
        '{1'b1, 6'd24, 32'h0000_5555, 6'd32, 32'h0},          // ES base
        '{1'b0, 6'd0,  32'h0,         6'd32, 32'h0000_5555},  // R12 legacy
        '{1'b1, 6'd5,  32'h0000_00FF, 6'd5,  32'h0},          // R2 illegal
        '{1'b0, 6'd0,  32'h0,         6'd19, 32'h0000_0002}   // R6 protected
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [5:0] widx,
                        input logic [DW-1:0] wd, input logic [5:0] ridx);
        @(negedge clk);
        wr_en = we; wr_idx = widx; wr_data = wd; rd_idx = ridx;
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0; rd_idx = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        step(1'b0, 6'd0, '0, 6'd0);
        chk("R1 cr0", rd_data, 32'h10);
        chk("R1 mode", cur_mode, 0);
        chk("R1 submode", cur_submode, 0);
        chk("R1 pulses", {inv_all, inv_nonglobal, wr_err}, 0);

        for (int i = 0; i < 12; i++) begin
            step(VEC_TBL[i].we, VEC_TBL[i].widx, VEC_TBL[i].wdata, VEC_TBL[i].ridx);
            chk($sformatf("table row %0d (R3 R12 R13 R2)", i), rd_data, VEC_TBL[i].exp);
            if (i == 11) chk("R2 wr_err", wr_err, 1);
        end

        step(1'b0, 6'd0, '0, 6'd7);
        chk("R2 rd_err", rd_err, 1);
        chk("R2 rd_data", rd_data, 0);
        step(1'b0, 6'd0, '0, 6'd45);
        chk("R2 unmapped", {rd_err, rd_data}, {1'b1, 32'h0});

        step(1'b1, 6'd20, 32'hFFFF_FFFE, 6'd20);
        step(1'b0, 6'd0, '0, 6'd20);
        chk("R4 tsc +1", rd_data, 32'hFFFF_FFFF);
        step(1'b0, 6'd0, '0, 6'd20);
        chk("R4 tsc wrap", rd_data, 32'h0);

        step(1'b1, 6'd16, 32'h1, 6'd0);
        step(1'b1, 6'd18, 32'h7, 6'd32);
        step(1'b0, 6'd0, '0, 6'd32);
        chk("R10 eff zeroed", rd_data, 0);
        chk("R11 cpl", cur_cpl, 3);
        chk("R10 legacy submode kept", cur_submode, 1);

        step(1'b1, 6'd0, 32'h8000_0001, 6'd0);
        step(1'b0, 6'd0, '0, 6'd16);
        chk("R5 lma set", rd_data, 32'h3);
        chk("R5 long", cur_mode, 1);
        chk("R6 64-bit", cur_submode, 4);
        chk("R7 pulse", inv_all, 1);
        step(1'b0, 6'd0, '0, 6'd16);
        chk("R7 single", inv_all, 0);

        step(1'b1, 6'd24, 32'h7777, 6'd32);
        step(1'b0, 6'd0, '0, 6'd32);
        chk("R12 64-bit no shadow", rd_data, 0);
        step(1'b0, 6'd0, '0, 6'd24);
        chk("R12 real base", rd_data, 32'h7777);

        step(1'b1, 6'd18, 32'h0, 6'd32);
        step(1'b0, 6'd0, '0, 6'd32);
        chk("R10 reload", rd_data, 32'h7777);
        chk("R10 compat", cur_submode, 3);
        chk("R11 cpl zero", cur_cpl, 0);
        step(1'b1, 6'd24, 32'h8888, 6'd32);
        step(1'b0, 6'd0, '0, 6'd32);
        chk("R12 compat shadow", rd_data, 32'h8888);

        step(1'b1, 6'd3, 32'h1000, 6'd3);
        step(1'b0, 6'd0, '0, 6'd3);
        chk("R8 nonglobal", {inv_nonglobal, inv_all}, 2'b10);

        step(1'b1, 6'd4, 32'h20, 6'd4);
        step(1'b0, 6'd0, '0, 6'd4);
        chk("R9 pae toggle", inv_all, 1);
        step(1'b1, 6'd4, 32'h21, 6'd4);
        step(1'b0, 6'd0, '0, 6'd4);
        chk("R9 other bit", inv_all, 0);

        step(1'b1, 6'd0, 32'h1, 6'd16);
        step(1'b0, 6'd0, '0, 6'd16);
        chk("R5 lma clear", rd_data, 32'h1);
        chk("R5 legacy", cur_mode, 0);
        chk("R6 protected", cur_submode, 1);
        chk("R7 pg off", inv_all, 1);

        step(1'b1, 6'd17, 32'h0002_0000, 6'd0);
        step(1'b1, 6'd0, 32'h0, 6'd0);
        step(1'b0, 6'd0, '0, 6'd0);
        chk("R6 v86", cur_submode, 2);
        chk("R3 et", rd_data, 32'h10);
        step(1'b1, 6'd17, 32'h0, 6'd0);
        step(1'b1, 6'd0, 32'h0, 6'd0);
        step(1'b0, 6'd0, '0, 6'd0);
        chk("R6 real", cur_submode, 0);

        step(1'b1, 6'd16, 32'h0, 6'd0);
        step(1'b1, 6'd0, 32'h8000_0000, 6'd16);
        step(1'b0, 6'd0, '0, 6'd16);
        chk("R7 no-lme flush", inv_all, 1);
        chk("R5 no-lme mode", cur_mode, 0);
        chk("R5 no-lme efer", rd_data, 0);
        chk("R6 no-lme real", cur_submode, 0);

        finish_run();
    end
endmodule